// File: doc/BRIEF.md
# USB Device Control Register

This block is the main control register of a USB device controller, together with the hardware that acts on its bits. Software writes a 32-bit word that holds a 7-bit device address, an address-enable flag, a controller enable, a detach command, a remote wake-up request and a pull-down disable. The block drives the pull resistor controls on the two data lines and the transceiver suspend control from the detach and pull-down bits. It turns the enable bit into a reset for the rest of the controller. It also compares incoming token addresses against the address that applies at that moment.

A remote wake-up request stays pending until the bus has been in suspend for a set number of millisecond ticks without a break. The block then raises an upstream resume level. That level holds until the resume logic reports completion, and on that report the request bit clears. A USB bus reset clears the address fields, the wake-up request and the pull-down disable. It does not touch the enable and detach bits.

Top module: `usbd_ctrl_reg`

## Requirements
- R1: After reset, the register reads 0x00000200: detach is set and every other field is zero. Both lines are pulled down, the transceiver suspend output is low and the controller reset output is low.
- R2: Field positions are: device address in bits 6:0, address enable in bit 7, controller enable in bit 8, detach in bit 9, wake-up request in bit 10, pull-down disable in bit 11. A write loads bits 11:0, and bits 31:12 always read zero.
- R3: The pull outputs decode {detach, pull-down disable} as follows: 00 gives a DP pull-up and a DM pull-down; 01 gives a DP pull-up only; 10 gives pull-downs on DP and DM; 11 drives no pull at all.
- R4: The transceiver suspend output (active low) is the inverse of detach. The controller reset output (active low) follows the enable bit.
- R5: Writing 1 to the wake-up bit sets the request. Writing 0 to it has no effect. The request stays set until it is served or a bus reset occurs.
- R6: The upstream resume output rises only when a request is pending and the suspend input has been high for at least SUSP_MS ticks without a break. Any cycle with suspend low restarts the count. Once raised, the output stays high until the resume-done pulse arrives.
- R7: On the resume-done pulse while the resume output is high, the resume output and the wake-up bit both clear at the same clock edge.
- R8: A bus reset clears the pull-down disable, wake-up, address enable and device address fields, and it drops the resume output. Enable and detach keep their values, or take the written values when a write happens in the same cycle. On the fields the bus reset clears, the bus reset wins over the write.
- R9: The address match output is high only for a valid token. With address enable at 0, the token address must be 0. With address enable at 1, the token address must equal the stored device address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Register read value |
| bus_reset_i | input | 1 | USB bus reset pulse |
| suspend_i | input | 1 | Bus is in suspend state |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| resume_done_i | input | 1 | Upstream resume completed |
| resume_o | output | 1 | Upstream resume request level |
| dp_pullup_o | output | 1 | Enable DP pull-up |
| dp_pulldown_o | output | 1 | Enable DP pull-down |
| dm_pulldown_o | output | 1 | Enable DM pull-down |
| xcvr_suspend_n_o | output | 1 | Transceiver suspend control, active low |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| tok_valid_i | input | 1 | Token address valid |
| tok_addr_i | input | 7 | Token address |
| addr_match_o | output | 1 | Token is addressed to this device |

## Verification
The hardest state to reach is an upstream resume that is almost ready. A pending request and a suspend count one tick short of the limit are not visible at any port. The bench reaches that state by holding suspend and counting ticks itself. It checks that the resume stays low, drops suspend for a single cycle and counts again, and expects the launch on the exact cycle after the final tick. It then checks the same-edge clear on resume-done, a re-launch while suspend is still held, and a bus reset that arrives in the same cycle as a full write.

// File: rtl/usbd_ctrl_pkg.sv
package usbd_ctrl_pkg;

  localparam int DEV_ADDR_W = 7;
  localparam int FIELD_W    = 12;

  // Packed layout matches bits 11:0 of the register word.
  typedef struct packed {
    logic                  pd_dis;
    logic                  wake;
    logic                  detach;
    logic                  enable;
    logic                  addr_en;
    logic [DEV_ADDR_W-1:0] dev_addr;
  } ctrl_fields_t;

  localparam ctrl_fields_t CTRL_RESET = '{
    pd_dis:   1'b0,
    wake:     1'b0,
    detach:   1'b1,
    enable:   1'b0,
    addr_en:  1'b0,
    dev_addr: '0
  };

  // Encoded as {detach, pd_dis}.
  typedef enum logic [1:0] {
    PULL_ATT_FULL  = 2'b00,
    PULL_ATT_DPONL = 2'b01,
    PULL_DET_LOW   = 2'b10,
    PULL_FLOAT     = 2'b11
  } pull_mode_t;

endpackage

// File: rtl/usbd_rst_sync.sv
module usbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/usbd_pull_decode.sv
module usbd_pull_decode
  import usbd_ctrl_pkg::*;
(
  input  pull_mode_t mode_i,
  output logic       dp_pullup_o,
  output logic       dp_pulldown_o,
  output logic       dm_pulldown_o
);

  always_comb begin
    dp_pullup_o   = 1'b0;
    dp_pulldown_o = 1'b0;
    dm_pulldown_o = 1'b0;
    case (mode_i)
      PULL_ATT_FULL: begin
        dp_pullup_o   = 1'b1;
        dm_pulldown_o = 1'b1;
      end
      PULL_ATT_DPONL: begin
        dp_pullup_o   = 1'b1;
      end
      PULL_DET_LOW: begin
        dp_pulldown_o = 1'b1;
        dm_pulldown_o = 1'b1;
      end
      default: begin
        dp_pullup_o   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/usbd_wake_seq.sv
module usbd_wake_seq #(
  parameter int SUSP_MS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_i,
  input  logic tick_i,
  input  logic wake_req_i,
  input  logic done_i,
  input  logic bus_reset_i,
  output logic resume_o,
  output logic elapsed_o
);

  localparam int CNT_W = $clog2(SUSP_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SUSP_MS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             resume_q, resume_d;

  assign elapsed_o = (cnt_q == CNT_LIMIT);

  // Suspend time counter: restarts on any non-suspend cycle, saturates.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!suspend_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (tick_i && !elapsed_o) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Resume level: launched once, held until completion.
  always_comb begin
    resume_d = resume_q;
    if (bus_reset_i)                          resume_d = 1'b0;
    else if (resume_q && done_i)              resume_d = 1'b0;
    else if (!resume_q && wake_req_i && elapsed_o) resume_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume_q <= 1'b0;
    else        resume_q <= resume_d;
  end

  assign resume_o = resume_q;

  a_r6_launch_after_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_q) |-> $past(cnt_q) == CNT_LIMIT);

  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_q && !done_i && !bus_reset_i) |=> resume_q);

  a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend_i |=> (cnt_q == '0));

endmodule

// File: rtl/usbd_addr_filter.sv
module usbd_addr_filter #(
  parameter int ADDR_W = 7
) (
  input  logic              tok_valid_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic              addr_en_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              match_o
);

  logic [ADDR_W-1:0] accept_addr;

  assign accept_addr = addr_en_i ? dev_addr_i : '0;
  assign match_o     = tok_valid_i && (tok_addr_i == accept_addr);

endmodule

// File: rtl/usbd_ctrl_reg.sv
module usbd_ctrl_reg
  import usbd_ctrl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SUSP_MS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic                  bus_reset_i,
  input  logic                  suspend_i,
  input  logic                  ms_tick_i,
  input  logic                  resume_done_i,
  output logic                  resume_o,
  output logic                  dp_pullup_o,
  output logic                  dp_pulldown_o,
  output logic                  dm_pulldown_o,
  output logic                  xcvr_suspend_n_o,
  output logic                  ctrl_rst_n_o,
  input  logic                  tok_valid_i,
  input  logic [DEV_ADDR_W-1:0] tok_addr_i,
  output logic                  addr_match_o
);

  localparam int PAD_W = DATA_W - FIELD_W;

  logic         rst_q_n;
  ctrl_fields_t cur_q, cur_d, wr_fields;
  logic         reg_load;
  logic         resume_q;
  logic         elapsed;
  logic         resume_served;
  logic         unused_wr_hi;

  usbd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign wr_fields     = ctrl_fields_t'(wr_data_i[FIELD_W-1:0]);
  assign unused_wr_hi  = ^wr_data_i[DATA_W-1:FIELD_W];
  assign resume_served = resume_q && resume_done_i;

  // Next state: write, then hardware clear, then bus reset (highest).
  always_comb begin
    cur_d = cur_q;
    if (wr_en_i) begin
      cur_d      = wr_fields;
      cur_d.wake = cur_q.wake | wr_fields.wake;
    end
    if (resume_served) cur_d.wake = 1'b0;
    if (bus_reset_i) begin
      cur_d.pd_dis   = 1'b0;
      cur_d.wake     = 1'b0;
      cur_d.addr_en  = 1'b0;
      cur_d.dev_addr = '0;
    end
  end

  assign reg_load = wr_en_i | bus_reset_i | resume_served;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      cur_q <= CTRL_RESET;
    else if (reg_load) cur_q <= cur_d;
  end

  assign rd_data_o        = {{PAD_W{1'b0}}, cur_q};
  assign xcvr_suspend_n_o = ~cur_q.detach;
  assign ctrl_rst_n_o     = cur_q.enable;

  usbd_pull_decode i_pull (
    .mode_i        (pull_mode_t'({cur_q.detach, cur_q.pd_dis})),
    .dp_pullup_o   (dp_pullup_o),
    .dp_pulldown_o (dp_pulldown_o),
    .dm_pulldown_o (dm_pulldown_o)
  );

  usbd_wake_seq #(.SUSP_MS(SUSP_MS)) i_wake (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .suspend_i   (suspend_i),
    .tick_i      (ms_tick_i),
    .wake_req_i  (cur_q.wake),
    .done_i      (resume_done_i),
    .bus_reset_i (bus_reset_i),
    .resume_o    (resume_q),
    .elapsed_o   (elapsed)
  );

  assign resume_o = resume_q;

  usbd_addr_filter #(.ADDR_W(DEV_ADDR_W)) i_filt (
    .tok_valid_i (tok_valid_i),
    .tok_addr_i  (tok_addr_i),
    .addr_en_i   (cur_q.addr_en),
    .dev_addr_i  (cur_q.dev_addr),
    .match_o     (addr_match_o)
  );

  a_r3_detach_no_pullup: assert property (@(posedge clk) disable iff (!rst_q_n)
    cur_q.detach |-> !dp_pullup_o);

  a_r5_wake_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cur_q.wake && !resume_served && !bus_reset_i) |=> cur_q.wake);

  a_r6_launch_needs_request: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(resume_q) |-> $past(cur_q.wake) && $past(elapsed));

  a_r7_wake_clears_on_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    resume_served |=> (!cur_q.wake && !resume_q));

  a_r8_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_reset_i |=> (cur_q.dev_addr == '0 && !cur_q.addr_en && !cur_q.pd_dis
                     && !cur_q.wake && !resume_q));

  a_r8_keeps_enable_detach: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_reset_i && !wr_en_i) |=> ($stable(cur_q.enable) && $stable(cur_q.detach)));

  a_r9_default_addr: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_match_o && !cur_q.addr_en) |-> (tok_addr_i == '0));

  a_r9_stored_addr: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_match_o && cur_q.addr_en) |-> (tok_addr_i == cur_q.dev_addr));

endmodule

// File: tb/test_usbd_ctrl_reg.sv
`timescale 1ns/1ps
module test_usbd_ctrl_reg;

  localparam int DATA_W  = 32;
  localparam int SUSP_MS = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              bus_reset, suspend, ms_tick, resume_done;
  logic              resume, dp_pu, dp_pd, dm_pd, xsusp_n, crst_n;
  logic              tok_valid;
  logic [6:0]        tok_addr;
  logic              match;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  usbd_ctrl_reg #(.DATA_W(DATA_W), .SUSP_MS(SUSP_MS)) i_usbd_ctrl_reg (
    .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .rd_data_o (rd_data), .bus_reset_i (bus_reset), .suspend_i (suspend),
    .ms_tick_i (ms_tick), .resume_done_i (resume_done), .resume_o (resume),
    .dp_pullup_o (dp_pu), .dp_pulldown_o (dp_pd), .dm_pulldown_o (dm_pd),
    .xcvr_suspend_n_o (xsusp_n), .ctrl_rst_n_o (crst_n),
    .tok_valid_i (tok_valid), .tok_addr_i (tok_addr), .addr_match_o (match)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d, input logic br);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; bus_reset = br;
    @(negedge clk);
    wr_en = 1'b0; bus_reset = 1'b0;
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bus_reset = 1'b0;
    suspend = 1'b0; ms_tick = 1'b0; resume_done = 1'b0;
    tok_valid = 1'b0; tok_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(rd_data, 32'h200, "R1 reset value");
    chk({dp_pu, dp_pd, dm_pd}, 3'b011, "R1 reset pulls");
    chk(xsusp_n, 1'b0, "R1 suspend control");
    chk(crst_n, 1'b0, "R1 controller reset");
    chk(resume, 1'b0, "R1 resume idle");

    // R2 field layout, upper bits read zero
    reg_write(32'hFFFF_F3A5, 1'b0);
    chk(rd_data, 32'h3A5, "R2 readback A");
    reg_write(32'hA000_0C5A, 1'b0);
    chk(rd_data, 32'hC5A, "R2 readback B");
    // R5 writing 0 to wake-up leaves request set
    reg_write(32'h0, 1'b0);
    chk(rd_data, 32'h400, "R5 wake write-0 no effect");
    pulse_bus_reset();
    chk(rd_data, 32'h000, "R8 bus reset clears wake");

    // R3/R4 sweep of detach, pull-down disable and enable
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 2; e++) begin
          reg_write((p << 11) | (d << 9) | (e << 8), 1'b0);
          chk(dp_pu, (d == 0), "R3 dp pull-up");
          chk(dp_pd, (d == 1 && p == 0), "R3 dp pull-down");
          chk(dm_pd, (p == 0), "R3 dm pull-down");
          chk(xsusp_n, (d == 0), "R4 suspend control");
          chk(crst_n, (e == 1), "R4 controller reset");
        end

    // R8 bus reset priority and retention
    reg_write(32'hFFF, 1'b1);
    chk(rd_data, 32'h300, "R8 reset beats write");
    reg_write(32'h3A5, 1'b0);
    pulse_bus_reset();
    chk(rd_data, 32'h300, "R8 keeps enable and detach");
    reg_write(32'h0FF, 1'b0);
    pulse_bus_reset();
    chk(rd_data, 32'h000, "R8 clears address fields");

    // R9 address filter sweep
    for (int s = 0; s < 5; s++) begin
      logic [6:0] stored;
      case (s)
        0: stored = 7'h00;
        1: stored = 7'h01;
        2: stored = 7'h2A;
        3: stored = 7'h55;
        default: stored = 7'h7F;
      endcase
      for (int ae = 0; ae < 2; ae++) begin
        reg_write((ae << 7) | 32'(stored) | 32'h100, 1'b0);
        tok_valid = 1'b0; tok_addr = ae ? stored : 7'h0;
        #1;
        chk(match, 1'b0, "R9 invalid token");
        tok_valid = 1'b1;
        for (int t = 0; t < 128; t++) begin
          tok_addr = 7'(t);
          #1;
          chk(match, (t == (ae ? int'(stored) : 0)), "R9 address match");
        end
        tok_valid = 1'b0;
      end
    end

    // R5/R6/R7 remote wake-up sequencing
    reg_write(32'h100, 1'b0);
    suspend = 1'b1;
    reg_write(32'h500, 1'b0);
    for (int i = 0; i < SUSP_MS - 1; i++) tick();
    idle(3);
    chk(resume, 1'b0, "R6 no launch before limit");
    chk(rd_data, 32'h500, "R5 request pending");
    suspend = 1'b0;
    @(negedge clk);
    suspend = 1'b1;
    for (int i = 0; i < SUSP_MS - 1; i++) tick();
    idle(2);
    chk(resume, 1'b0, "R6 count restarted");
    tick();
    chk(resume, 1'b0, "R6 launch one cycle after last tick");
    @(negedge clk);
    chk(resume, 1'b1, "R6 launch");
    idle(5);
    chk(resume, 1'b1, "R6 held until done");
    chk(rd_data, 32'h500, "R5 request held during resume");
    resume_done = 1'b1;
    @(negedge clk);
    resume_done = 1'b0;
    chk(resume, 1'b0, "R7 resume cleared");
    chk(rd_data, 32'h100, "R7 wake cleared same edge");
    reg_write(32'h500, 1'b0);
    chk(resume, 1'b0, "R6 relaunch not yet");
    @(negedge clk);
    chk(resume, 1'b1, "R6 relaunch while suspended");
    pulse_bus_reset();
    chk(resume, 1'b0, "R8 bus reset drops resume");
    chk(rd_data, 32'h100, "R8 bus reset clears wake");
    idle(3);
    chk(resume, 1'b0, "R8 no relaunch after reset");

    finish_run();
  end

endmodule